// File: doc/BRIEF.md
# Boot Image Loader with Memory Port Handoff

This block runs right after reset. It copies a program image from a read-only instruction store into main memory, one word per clock. The first word lands at a fixed entry address and each next word lands one word higher. During the copy the block owns the memory write port, and any write the processor requests is kept away from memory.

When the last word has been written, the block raises a sticky completion flag. From then on the memory port carries the processor's requests unchanged, and an instruction-valid output tells the processor it may start fetching. The processor holds its program counter while instruction-valid is low.

The image length, data width, address width and entry address are parameters. The instruction store is assumed to return data one cycle after it is addressed.

Top module: `boot_image_loader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `load_done`, `insn_valid` and `mem_wr_en` are 0 and `rom_addr` is 0.
- R2: For k = 0..IMG_WORDS-1, the write in cycle k+1 after reset release goes to address ENTRY_ADDR + k·(DATA_W/8). It carries image word k and has every strobe bit set. There is exactly one write per cycle, in ascending order.
- R3: `rom_addr` equals the cycle count c since reset release for c ≤ IMG_WORDS-1. Each write uses the data the store returned one cycle after that address was presented.
- R4: `load_done` rises in cycle IMG_WORDS+1, the cycle after the last copy write. It stays at 1 until the next reset.
- R5: While `load_done` is 0, a processor write request reaches no memory word, whether it targets the image area or any other address.
- R6: While `load_done` is 1, `mem_wr_en`, `mem_addr`, `mem_wdata` and `mem_strb` equal the processor's request inputs in the same cycle. Partial strobes are passed through unchanged.
- R7: `insn_valid` is 1 exactly when `load_done` is 1, so it is never high before the copy has ended.
- R8: After the handoff the loader makes no more writes: with `cpu_wr_en` at 0, `mem_wr_en` stays 0.
- R9: A reset asserted during a copy aborts it. The next copy starts again from word 0 and takes whatever image the store returns at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | ROM_AW | Word index presented to the instruction store |
| rom_data | input | DATA_W | Store data, valid one cycle after its address |
| cpu_wr_en | input | 1 | Processor write request |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_strb | input | DATA_W/8 | Processor byte-lane strobes |
| mem_wr_en | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_strb | output | DATA_W/8 | Memory byte-lane strobes |
| load_done | output | 1 | Copy complete; port belongs to the processor |
| insn_valid | output | 1 | Processor may fetch and advance its program counter |

## Verification
The copy is run with two different image patterns, each word carrying its own index, so a dropped, repeated or misordered word shows up in the final memory contents. The same runs check the one-cycle store latency. During the copy the processor keeps requesting writes, alternating between a word inside the image and a word outside it, so a leak is caught wherever it lands. After the handoff a partial-strobe processor write and a stretch of idle cycles separate correct pass-through from leftover loader writes. A reset in the middle of a copy, followed by a new image, shows that the copy starts again from word 0.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
   typedef enum logic [1:0] {
      LD_COPY = 2'd0,
      LD_TAIL = 2'd1,
      LD_RUN  = 2'd2
   } ldr_state_e;

   function automatic int unsigned idx_width(input int unsigned words);
      return (words > 1) ? $clog2(words) : 1;
   endfunction
endpackage

// File: rtl/boot_ldr_seq.sv
module boot_ldr_seq
   import boot_ldr_pkg::*;
#(
   parameter int unsigned IMG_WORDS = 16,
   parameter int unsigned ROM_AW    = idx_width(IMG_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ROM_AW-1:0] rd_idx,
   output logic [ROM_AW-1:0] wr_idx,
   output logic              wr_pend,
   output logic              done
);
   localparam logic [ROM_AW-1:0] LAST_IDX = ROM_AW'(IMG_WORDS - 1);

   ldr_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LD_COPY;
         rd_idx  <= '0;
         wr_idx  <= '0;
         wr_pend <= 1'b0;
      end else begin
         case (state)
            LD_COPY: begin
               wr_pend <= 1'b1;
               wr_idx  <= rd_idx;
               if (rd_idx == LAST_IDX) state <= LD_TAIL;
               else                    rd_idx <= rd_idx + 1'b1;
            end
            LD_TAIL: begin
               wr_pend <= 1'b0;
               state   <= LD_RUN;
            end
            default: begin
               wr_pend <= 1'b0;
               state   <= LD_RUN;
            end
         endcase
      end
   end

   assign done = (state == LD_RUN);

   // R3: store address advances by one word per cycle while copying
   assert_rom_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && state == LD_COPY && $past(state) == LD_COPY)
         |-> rd_idx == $past(rd_idx) + 1'b1);

   // R2: consecutive copy writes use consecutive word indices
   assert_write_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && wr_pend && $past(wr_pend)) |-> wr_idx == $past(wr_idx) + 1'b1);

   // R8: no copy write once the run state is reached
   assert_no_late_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_pend);
endmodule

// File: rtl/boot_ldr_portsel.sv
module boot_ldr_portsel #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8
) (
   input  logic              sel_cpu,
   input  logic              ldr_wr_en,
   input  logic [ADDR_W-1:0] ldr_addr,
   input  logic [DATA_W-1:0] ldr_wdata,
   input  logic              cpu_wr_en,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [LANES-1:0]  cpu_strb,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [LANES-1:0]  mem_strb
);
   logic [LANES-1:0] ldr_strb;

   // copy writes always fill every byte lane
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign ldr_strb[g] = ldr_wr_en;
   end

   always_comb begin
      if (sel_cpu) begin
         mem_wr_en = cpu_wr_en;
         mem_addr  = cpu_addr;
         mem_wdata = cpu_wdata;
         mem_strb  = cpu_strb;
      end else begin
         mem_wr_en = ldr_wr_en;
         mem_addr  = ldr_addr;
         mem_wdata = ldr_wdata;
         mem_strb  = ldr_strb;
      end
   end
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
   import boot_ldr_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       IMG_WORDS  = 16,
   parameter logic [ADDR_W-1:0] ENTRY_ADDR = 'h40,
   localparam int unsigned      ROM_AW     = idx_width(IMG_WORDS),
   localparam int unsigned      LANES      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data,
   input  logic              cpu_wr_en,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [LANES-1:0]  cpu_strb,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [LANES-1:0]  mem_strb,
   output logic              load_done,
   output logic              insn_valid
);
   localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(LANES);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ENTRY_ADDR + ADDR_W'(IMG_WORDS - 1) * STEP;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (IMG_WORDS < 1) begin : g_bad_len
      $error("IMG_WORDS must be at least 1");
   end
   if ((ENTRY_ADDR % STEP) != 0) begin : g_bad_entry
      $error("ENTRY_ADDR must be word aligned");
   end

   logic [ROM_AW-1:0] wr_idx;
   logic              wr_pend;
   logic              done;
   logic [ADDR_W-1:0] ldr_addr;

   boot_ldr_seq #(.IMG_WORDS(IMG_WORDS), .ROM_AW(ROM_AW)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (rom_addr),
      .wr_idx (wr_idx),
      .wr_pend(wr_pend),
      .done   (done)
   );

   assign ldr_addr = ENTRY_ADDR + ADDR_W'(wr_idx) * STEP;

   boot_ldr_portsel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_sel (
      .sel_cpu  (done),
      .ldr_wr_en(wr_pend),
      .ldr_addr (ldr_addr),
      .ldr_wdata(rom_data),
      .cpu_wr_en(cpu_wr_en),
      .cpu_addr (cpu_addr),
      .cpu_wdata(cpu_wdata),
      .cpu_strb (cpu_strb),
      .mem_wr_en(mem_wr_en),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_strb (mem_strb)
   );

   assign load_done  = done;
   assign insn_valid = done;

   // R4: completion is sticky
   assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   // R4: completion follows directly on the write of the last image word
   assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(load_done)) |-> ($past(mem_wr_en) && $past(mem_addr) == LAST_ADDR));

   // R2: copy writes fill every lane and stay inside the image area
   assert_copy_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_done && mem_wr_en) |-> (mem_strb == '1 && mem_addr >= ENTRY_ADDR && mem_addr <= LAST_ADDR));

   // R7: fetching is never enabled before the copy ends
   assert_fetch_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |-> load_done);

   // R8: an idle processor produces no memory write after handoff
   assert_idle_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && !cpu_wr_en) |-> !mem_wr_en);
endmodule

// File: tb/sim_boot_image_loader.sv
`timescale 1ns/1ps
module sim_boot_image_loader;
   localparam int          N     = 16;
   localparam logic [31:0] ENTRY = 32'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rom_addr;
   logic [31:0] rom_data = '0;
   logic        cpu_wr_en = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_strb = '0;
   logic        mem_wr_en;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_strb;
   logic        load_done;
   logic        insn_valid;

   logic [7:0]  seed = 8'h11;
   logic        mem_clr = 1'b0;
   logic [31:0] mem [64];
   int          checks = 0;
   int          failures = 0;
   bit          ended = 1'b0;

   always #10 clk = ~clk;

   boot_image_loader #(.IMG_WORDS(N), .ENTRY_ADDR(ENTRY)) u0 (
      .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
      .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_strb(cpu_strb),
      .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_strb(mem_strb),
      .load_done(load_done), .insn_valid(insn_valid)
   );

   function automatic logic [31:0] img_word(input logic [7:0] s, input int k);
      return {s, 8'(k), 16'hC0DE ^ 16'(k * 37)};
   endfunction

   function automatic logic [31:0] init_word(input int i);
      return 32'h5A5A_0000 | 32'(i);
   endfunction

   // store model: one cycle of read latency
   always @(posedge clk) rom_data <= img_word(seed, int'(rom_addr));

   // memory model
   always @(posedge clk) begin
      if (mem_clr) begin
         for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      end else if (mem_wr_en) begin
         for (int b = 0; b < 4; b++)
            if (mem_strb[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      mem_clr = 1'b1;
      cpu_wr_en = 1'b0;
      repeat (2) @(negedge clk);
      mem_clr = 1'b0;
   endtask

   // R1 / R3: state held in reset and in the first cycle after release
   task automatic t_reset_state();
      do_reset();
      #1;
      chk(load_done == 1'b0, "R1 load_done in reset", 32'(load_done), 0);
      chk(insn_valid == 1'b0, "R1 insn_valid in reset", 32'(insn_valid), 0);
      chk(mem_wr_en == 1'b0, "R1 mem_wr_en in reset", 32'(mem_wr_en), 0);
      rst_n = 1'b1;
      #1;
      chk(rom_addr == 4'd0, "R3 rom_addr cycle 0", 32'(rom_addr), 0);
      chk(mem_wr_en == 1'b0, "R1 no write cycle 0", 32'(mem_wr_en), 0);
      chk(load_done == 1'b0, "R1 load_done cycle 0", 32'(load_done), 0);
   endtask

   // R2 R3 R4 R5 R7: whole copy while the processor keeps requesting writes
   task automatic t_full_load(input logic [7:0] s);
      seed = s;
      do_reset();
      rst_n = 1'b1;
      cpu_wr_en = 1'b1;
      cpu_wdata = 32'hDEAD_BEEF;
      cpu_strb  = 4'hF;
      cpu_addr  = 32'h08;
      for (int c = 1; c <= N; c++) begin
         @(negedge clk);
         chk(mem_wr_en == 1'b1, "R2 write each cycle", 32'(mem_wr_en), 1);
         chk(mem_addr == ENTRY + 32'(4 * (c - 1)), "R2 write address", mem_addr, ENTRY + 32'(4 * (c - 1)));
         chk(mem_wdata == img_word(s, c - 1), "R3 write data", mem_wdata, img_word(s, c - 1));
         chk(mem_strb == 4'hF, "R2 full strobe", 32'(mem_strb), 32'hF);
         chk(rom_addr == 4'((c < N) ? c : N - 1), "R3 rom_addr", 32'(rom_addr), 32'((c < N) ? c : N - 1));
         chk(load_done == 1'b0, "R4 not done early", 32'(load_done), 0);
         chk(insn_valid == 1'b0, "R7 fetch held", 32'(insn_valid), 0);
         cpu_addr = (c % 2 == 1) ? ENTRY : 32'h08;
         if (c == N) cpu_wr_en = 1'b0;
      end
      @(negedge clk);
      chk(load_done == 1'b1, "R4 done after last write", 32'(load_done), 1);
      chk(insn_valid == 1'b1, "R7 fetch enabled", 32'(insn_valid), 1);
      for (int k = 0; k < N; k++)
         chk(mem[16 + k] == img_word(s, k), "R2 memory image", mem[16 + k], img_word(s, k));
      chk(mem[2] == init_word(2), "R5 outside word untouched", mem[2], init_word(2));
      chk(mem[15] == init_word(15), "R5 word below image untouched", mem[15], init_word(15));
   endtask

   // R4 R6 R8: processor owns the port after handoff
   task automatic t_handoff();
      cpu_wr_en = 1'b1;
      cpu_addr  = 32'h10;
      cpu_wdata = 32'h1234_ABCD;
      cpu_strb  = 4'b0011;
      #1;
      chk(mem_wr_en == 1'b1, "R6 enable passthrough", 32'(mem_wr_en), 1);
      chk(mem_addr == 32'h10, "R6 address passthrough", mem_addr, 32'h10);
      chk(mem_wdata == 32'h1234_ABCD, "R6 data passthrough", mem_wdata, 32'h1234_ABCD);
      chk(mem_strb == 4'b0011, "R6 strobe passthrough", 32'(mem_strb), 32'h3);
      @(negedge clk);
      cpu_wr_en = 1'b0;
      chk(mem[4] == {init_word(4)[31:16], 16'hABCD}, "R6 partial write lands", mem[4],
          {init_word(4)[31:16], 16'hABCD});
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         chk(mem_wr_en == 1'b0, "R8 no loader write after handoff", 32'(mem_wr_en), 0);
         chk(load_done == 1'b1, "R4 done stays high", 32'(load_done), 1);
      end
   endtask

   // R9: reset in the middle of a copy restarts from word 0
   task automatic t_abort_restart();
      seed = 8'h33;
      do_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(mem_addr == ENTRY + 32'd16, "R9 mid copy position", mem_addr, ENTRY + 32'd16);
      rst_n = 1'b0;
      #1;
      chk(rom_addr == 4'd0, "R9 index cleared by reset", 32'(rom_addr), 0);
      chk(mem_wr_en == 1'b0, "R9 write dropped by reset", 32'(mem_wr_en), 0);
      t_full_load(8'h7E);
   endtask

   initial begin
      t_reset_state();
      t_full_load(8'h11);
      t_handoff();
      t_abort_restart();
      t_handoff();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule